// File: doc/BRIEF.md
# Posted CPU Write Buffer

This block sits between the CPU write port and the arbiter of a display controller. In posted mode each CPU write goes into a four-entry queue and is acknowledged in the same cycle, so the CPU never waits while space remains. The queue then drains toward the memory side, one entry per grant, in arrival order. Each entry carries the address, the data, one enable bit for each byte, and a flag that marks an I/O register write apart from a memory write.

While any entry is still queued, the block holds back a CPU read of display memory and a new I/O write. This keeps software from seeing data older than its own queued writes. With posting turned off, a CPU write is presented on the drain port as it arrives, and the CPU is acknowledged only when the arbiter grants it. Turning posting off takes effect only once the queue is empty.

Top module: `wbuf_top`

## Requirements
- R1: During reset and at its release the block reports empty, not full, no drain request and no CPU acknowledge, and it starts in direct (not posted) mode.
- R2: In posted mode, a memory write (cpu_wr_io=0) that meets a non-full buffer is acknowledged in the same cycle and queued at the next clock edge.
- R3: Queued entries leave in first-in first-out order. An entry is removed exactly when drn_req and drn_gnt are high in the same cycle, and drn_addr/drn_data show the oldest entry.
- R4: buf_full is high when 4 entries are held and buf_empty when none are. A write that meets a full buffer is not acknowledged, raises cpu_stall and is accepted once an entry has drained. Fullness is registered, so a drain in the same cycle does not free a slot for that cycle.
- R5: In posted mode drn_req is high exactly when the buffer is not empty.
- R6: cpu_stall is high whenever cpu_rd_req is high and the buffer is not empty.
- R7: An I/O write (cpu_wr_io=1) in posted mode is acknowledged only when the buffer is empty. Until then it raises cpu_stall.
- R8: In direct mode the drain port carries the CPU write unchanged, drn_req follows cpu_wr_req, and cpu_ack is cpu_wr_req and drn_gnt together. Otherwise cpu_stall is raised.
- R9: Setting cfg_post_en selects posted mode from the next cycle. Clearing it returns to direct mode only after a clock edge at which the buffer is empty and nothing is pushed.
- R10: Each entry keeps the 4 byte-enable bits and the I/O flag with its address and data, and drn_be/drn_io show them for the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_post_en | input | 1 | 1 selects posted operation, 0 selects write-through |
| cpu_wr_req | input | 1 | CPU write request, held until acknowledged |
| cpu_wr_addr | input | ADDR_W | Write address |
| cpu_wr_data | input | DATA_W | Write data |
| cpu_wr_be | input | DATA_W/8 | Byte enables |
| cpu_wr_io | input | 1 | 1 for an I/O register write, 0 for memory |
| cpu_rd_req | input | 1 | CPU display-memory read request |
| cpu_ack | output | 1 | Write completed this cycle |
| cpu_stall | output | 1 | CPU must wait this cycle |
| drn_req | output | 1 | Request for a CPU memory cycle toward the arbiter |
| drn_gnt | input | 1 | Arbiter takes the presented write this cycle |
| drn_addr | output | ADDR_W | Presented write address |
| drn_data | output | DATA_W | Presented write data |
| drn_be | output | DATA_W/8 | Presented byte enables |
| drn_io | output | 1 | Presented I/O flag |
| buf_empty | output | 1 | No entries held |
| buf_full | output | 1 | All entries held |

## Verification
The bench attacks the full-buffer edge. It holds a fifth write against a full queue and grants one drain, which checks that the write is not taken in the drain cycle and is not lost afterwards. A design that dropped or duplicated it would drain the wrong sequence. It queues entries and then lowers the enable. A buffer that switched to write-through at once would strand the queued entries and expose the CPU write on the drain port too early. Reads and I/O writes are issued against a partly filled queue, where a missing ordering stall would show up as an early acknowledge. A long run of random requests, grants and mode changes compares every output against a queue model on every cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Advance a ring index, wrapping at depth.
  function automatic int unsigned ring_step(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle of pushes and pops.
  function automatic int unsigned occ_after(input int unsigned occ, input logic push, input logic pop);
    int unsigned r;
    r = occ;
    if (push) r = r + 1;
    if (pop)  r = r - 1;
    return r;
  endfunction

  // Posted acceptance: room left, and I/O writes only into an empty buffer.
  function automatic logic posted_take(input logic wr, input logic io, input logic full,
                                       input logic empty);
    return wr && !full && (!io || empty);
  endfunction

  // Mode register update: enable sets at once, disable waits for a quiet, empty buffer.
  function automatic logic mode_after(input logic en, input logic cur, input logic empty,
                                      input logic push);
    return en || (cur && !(empty && !push));
  endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH = 4,
  parameter int EW    = 53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_ent,
  input  logic          pop,
  output logic [EW-1:0] head_ent,
  output logic          empty,
  output logic          full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [EW-1:0]    slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PTR_W'(i)) slot[i] <= push_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wbuf_pkg::ring_step(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(wbuf_pkg::ring_step(32'(rd_ptr), DEPTH));
      occ <= CNT_W'(wbuf_pkg::occ_after(32'(occ), push, pop));
    end
  end

  assign head_ent = slot[rd_ptr];
  assign empty    = (occ == '0);
  assign full     = (occ == CNT_W'(DEPTH));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  a_r3_occ_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(occ));
endmodule

// File: rtl/wbuf_mode.sv
module wbuf_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic empty,
  input  logic push,
  output logic post_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) post_mode <= 1'b0;
    else        post_mode <= wbuf_pkg::mode_after(cfg_en, post_mode, empty, push);
  end

  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (post_mode && !empty) |=> post_mode);
  a_r9_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && empty && !push) |=> !post_mode);
endmodule

// File: rtl/wbuf_route.sv
module wbuf_route #(
  parameter int EW = 53
) (
  input  logic          post_mode,
  input  logic          cpu_wr_req,
  input  logic          cpu_wr_io,
  input  logic          cpu_rd_req,
  input  logic [EW-1:0] cpu_ent,
  input  logic [EW-1:0] head_ent,
  input  logic          empty,
  input  logic          full,
  input  logic          drn_gnt,
  output logic          push,
  output logic          pop,
  output logic          cpu_ack,
  output logic          cpu_stall,
  output logic          drn_req,
  output logic [EW-1:0] drn_ent
);
  logic take_posted;
  logic order_hold;

  assign take_posted = wbuf_pkg::posted_take(cpu_wr_req, cpu_wr_io, full, empty);
  assign order_hold  = cpu_rd_req && !empty;

  always_comb begin
    if (post_mode) begin
      push    = take_posted;
      pop     = !empty && drn_gnt;
      cpu_ack = take_posted;
      drn_req = !empty;
      drn_ent = head_ent;
    end else begin
      push    = 1'b0;
      pop     = 1'b0;
      cpu_ack = cpu_wr_req && drn_gnt;
      drn_req = cpu_wr_req;
      drn_ent = cpu_ent;
    end
    cpu_stall = (cpu_wr_req && !cpu_ack) || order_hold;
  end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 32,
  parameter int  DEPTH  = 4,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_post_en,
  input  logic              cpu_wr_req,
  input  logic [ADDR_W-1:0] cpu_wr_addr,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic [BE_W-1:0]   cpu_wr_be,
  input  logic              cpu_wr_io,
  input  logic              cpu_rd_req,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic              drn_req,
  input  logic              drn_gnt,
  output logic [ADDR_W-1:0] drn_addr,
  output logic [DATA_W-1:0] drn_data,
  output logic [BE_W-1:0]   drn_be,
  output logic              drn_io,
  output logic              buf_empty,
  output logic              buf_full
);
  localparam int EW = ADDR_W + DATA_W + BE_W + 1;

  logic [EW-1:0] cpu_ent, head_ent, drn_ent;
  logic          push, pop, post_mode;

  assign cpu_ent = {cpu_wr_io, cpu_wr_be, cpu_wr_data, cpu_wr_addr};

  wbuf_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(cpu_ent), .pop(pop),
    .head_ent(head_ent), .empty(buf_empty), .full(buf_full)
  );

  wbuf_mode u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_post_en), .empty(buf_empty),
    .push(push), .post_mode(post_mode)
  );

  wbuf_route #(.EW(EW)) u_route (
    .post_mode(post_mode), .cpu_wr_req(cpu_wr_req), .cpu_wr_io(cpu_wr_io),
    .cpu_rd_req(cpu_rd_req), .cpu_ent(cpu_ent), .head_ent(head_ent),
    .empty(buf_empty), .full(buf_full), .drn_gnt(drn_gnt), .push(push), .pop(pop),
    .cpu_ack(cpu_ack), .cpu_stall(cpu_stall), .drn_req(drn_req), .drn_ent(drn_ent)
  );

  assign drn_addr = drn_ent[ADDR_W-1:0];
  assign drn_data = drn_ent[ADDR_W +: DATA_W];
  assign drn_be   = drn_ent[ADDR_W+DATA_W +: BE_W];
  assign drn_io   = drn_ent[EW-1];

  a_r2_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (post_mode && cpu_wr_req && !cpu_wr_io && !buf_full) |-> cpu_ack);
  a_r5_drain_req: assert property (@(posedge clk) disable iff (!rst_n)
    (post_mode && !buf_empty) |-> drn_req);
  a_r6_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_req && !buf_empty) |-> cpu_stall);
  a_r7_io_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (post_mode && cpu_wr_req && cpu_wr_io && !buf_empty) |-> !cpu_ack);
  a_r8_direct_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_mode && cpu_ack) |-> drn_gnt);
  a_r4_full_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (post_mode && buf_full) |-> !cpu_ack);
endmodule

// File: tb/wbuf_top_tb.sv
module wbuf_top_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int NE = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_post_en = 0, cpu_wr_req = 0, cpu_wr_io = 0, cpu_rd_req = 0, drn_gnt = 0;
  logic [AW-1:0] cpu_wr_addr = '0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic [BW-1:0] cpu_wr_be = '0;
  logic cpu_ack, cpu_stall, drn_req, drn_io, buf_empty, buf_full;
  logic [AW-1:0] drn_addr;
  logic [DW-1:0] drn_data;
  logic [BW-1:0] drn_be;

  always #5 clk = ~clk;

  wbuf_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(NE)) u_dut (.*);

  int nchk = 0, nerr = 0;
  bit finished = 0;

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [BW-1:0] b; logic io; } item_t;
  item_t q[$];
  bit m_mode = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // Reference model: compare mid-cycle, then step to the state after the next edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_mode = 0;
      chk("R1", "empty in reset", buf_empty, 1);
      chk("R1", "full in reset", buf_full, 0);
      chk("R1", "ack in reset", cpu_ack, 0);
      if (!cpu_wr_req) chk("R1", "drn_req in reset", drn_req, 0);
    end else begin
      bit e, f, ack, req, take, pushed, st;
      item_t hd;
      string st_tag;
      e = (q.size() == 0);
      f = (q.size() == NE);
      chk("R4", "buf_empty", buf_empty, e);
      chk("R4", "buf_full", buf_full, f);
      if (m_mode) begin
        take = cpu_wr_req && !f && (!cpu_wr_io || e);
        ack = take;
        req = !e;
        chk(cfg_post_en ? "R2" : "R9", "posted ack", cpu_ack, ack);
        chk(cfg_post_en ? "R5" : "R9", "posted drn_req", drn_req, req);
        if (!e) begin
          hd = q[0];
          chk("R3", "drn_addr", drn_addr, hd.a);
          chk("R3", "drn_data", drn_data, hd.d);
          chk("R10", "drn_be", drn_be, hd.b);
          chk("R10", "drn_io", drn_io, hd.io);
        end
      end else begin
        take = 0;
        ack = cpu_wr_req && drn_gnt;
        req = cpu_wr_req;
        chk("R8", "direct ack", cpu_ack, ack);
        chk("R8", "direct drn_req", drn_req, req);
        if (cpu_wr_req) begin
          chk("R8", "direct addr", drn_addr, cpu_wr_addr);
          chk("R8", "direct data", drn_data, cpu_wr_data);
          chk("R8", "direct be", drn_be, cpu_wr_be);
          chk("R8", "direct io", drn_io, cpu_wr_io);
        end
      end
      st = (cpu_wr_req && !ack) || (cpu_rd_req && !e);
      if (cpu_rd_req && !e)                          st_tag = "R6";
      else if (m_mode && cpu_wr_req && cpu_wr_io && !e) st_tag = "R7";
      else                                           st_tag = "R4";
      chk(st_tag, "cpu_stall", cpu_stall, st);
      // advance
      pushed = take;
      if (m_mode && !e && drn_gnt) void'(q.pop_front());
      if (take) q.push_back('{a: cpu_wr_addr, d: cpu_wr_data, b: cpu_wr_be, io: cpu_wr_io});
      m_mode = cfg_post_en || (m_mode && !(e && !pushed));
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Issue one write and hold it until acknowledged.
  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b, input logic io);
    bit got;
    cpu_wr_req = 1; cpu_wr_addr = a; cpu_wr_data = d; cpu_wr_be = b; cpu_wr_io = io;
    do begin
      @(negedge clk); got = cpu_ack;
      @(posedge clk); #1;
    end while (!got);
    cpu_wr_req = 0; cpu_wr_io = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    cfg_post_en = 1;
    cyc(2);
    // R2/R4: fill all four entries, each acked at once
    for (int i = 0; i < NE; i++) do_wr(AW'(16'h100 + i), DW'(32'hA000_0000 + i), BW'(i + 1), 1'b0);
    // R4: fifth write waits on a full buffer, then lands after one drain
    fork
      do_wr(16'h1FF, 32'hDEAD_BEEF, 4'hC, 1'b0);
      begin cyc(3); drn_gnt = 1; cyc(1); drn_gnt = 0; end
    join
    // R3: drain everything in order
    drn_gnt = 1; cyc(8); drn_gnt = 0;
    // R6: read held back while entries remain
    do_wr(16'h200, 32'h1111_2222, 4'hF, 1'b0);
    do_wr(16'h204, 32'h3333_4444, 4'h3, 1'b0);
    cpu_rd_req = 1; cyc(3);
    drn_gnt = 1; cyc(3); cpu_rd_req = 0; drn_gnt = 0;
    // R7: I/O write waits for an empty buffer
    do_wr(16'h300, 32'h5555_6666, 4'h1, 1'b0);
    do_wr(16'h304, 32'h7777_8888, 4'h2, 1'b0);
    fork
      do_wr(16'h03C4, 32'h0000_00AB, 4'h1, 1'b1);
      begin cyc(4); drn_gnt = 1; end
    join
    cyc(3); drn_gnt = 0;
    // R9: disable while entries queued; writes still post until empty
    do_wr(16'h400, 32'h0101_0101, 4'h8, 1'b0);
    do_wr(16'h404, 32'h0202_0202, 4'h4, 1'b0);
    do_wr(16'h408, 32'h0303_0303, 4'h2, 1'b0);
    cfg_post_en = 0;
    cyc(3);
    do_wr(16'h40C, 32'h0404_0404, 4'h1, 1'b1 ^ 1'b1);
    drn_gnt = 1; cyc(6); drn_gnt = 0;
    // R8: write-through waits for the grant
    fork
      do_wr(16'h500, 32'hCAFE_F00D, 4'h6, 1'b0);
      begin cyc(2); drn_gnt = 1; end
    join
    drn_gnt = 0;
    cyc(2);
    // Mixed random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      cpu_wr_req  = ($urandom_range(0, 2) != 0);
      cpu_wr_addr = AW'($urandom);
      cpu_wr_data = $urandom;
      cpu_wr_be   = BW'($urandom);
      cpu_wr_io   = ($urandom_range(0, 5) == 0);
      cpu_rd_req  = ($urandom_range(0, 4) == 0);
      drn_gnt     = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 63) == 0) cfg_post_en = ~cfg_post_en;
      cyc(1);
    end
    cpu_wr_req = 0; cpu_rd_req = 0; drn_gnt = 1; cfg_post_en = 1;
    cyc(10);
    report();
  end
endmodule